// File: doc/BRIEF.md
# Two-Bit Float Arithmetic Unit

This unit computes on a four-value floating-point format held in two bits: zero, plus one, minus one and a single NaN code. A caller presents two operands and an opcode together with a valid strobe; one clock later the unit presents a registered 2-bit result, a registered comparison flag and an output valid. Arithmetic that would leave the representable range (such as +1 plus +1) saturates to NaN, and any NaN operand propagates to the result.

The comparison group separates two notions of equality. Identity is a bitwise test, so NaN is identical to NaN. Ordered equality is false whenever either side is NaN. The ordered relations less-than, greater-than, less-or-equal and greater-or-equal build on the same rule. A build-time parameter selects how the multiplier is realised. It can be a small lookup table filled from signed products when the design is elaborated, or a few gates.

Top module: `tf2_alu`

## Requirements
- R1: Codes are 2'b00 = 0.0, 2'b01 = +1.0, 2'b11 = -1.0, 2'b10 = NaN. While `rst` is high at a clock edge, `out_valid`, `res_o` and `flag_o` all become 0.
- R2: `out_valid` is high in the cycle after an edge that sampled `in_valid` high, and low otherwise. At an edge where `in_valid` is low, `res_o` and `flag_o` keep their values.
- R3: Opcode 0 adds: a NaN operand gives NaN; otherwise the sum is exact when it is -1, 0 or +1, and NaN when it is ±2.
- R4: Opcode 2 negates operand A (0→0, +1→-1, -1→+1, NaN→NaN). Opcode 1 returns A plus the negation of B, under the rules of R3.
- R5: Opcode 3 multiplies: a NaN operand gives NaN, a zero operand gives zero, and otherwise the product is +1 for equal signs and -1 for unequal signs.
- R6: Opcode 4 returns the reciprocal of A (0→NaN, ±1 unchanged, NaN→NaN). Opcode 5 returns A multiplied by the reciprocal of B.
- R7: Opcode 6 raises the flag exactly when the two codes are bitwise equal, NaN against NaN included.
- R8: Opcode 7 raises the flag when the codes are equal and neither is NaN.
- R9: Opcode 8 raises the flag for A<B and opcode 9 for A>B, in the order -1 < 0 < +1. Either flag is false if an operand is NaN.
- R10: Opcode 10 is less-than OR ordered equality. Opcode 11 is greater-than OR ordered equality.
- R11: For opcodes 6 to 11 the result is 2'b00. For every other opcode the flag is 0.
- R12: Opcodes 12 to 15 return NaN with the flag at 0.
- R13: Both settings of `MUL_TABLE` produce identical outputs for every opcode and operand pair.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands and opcode are presented this cycle |
| op_i | input | 4 | Operation select |
| a_i | input | 2 | First operand code |
| b_i | input | 2 | Second operand code |
| out_valid | output | 1 | Result and flag hold a new computation |
| res_o | output | 2 | Result code |
| flag_o | output | 1 | Comparison outcome |

## Verification
The bench builds two copies of the unit side by side: one with `MUL_TABLE` = 0 (gate-level multiplier) and one with `MUL_TABLE` = 1 (elaborated product table). Every input stimulus goes to both copies. This puts the equivalence of the two multiplier variants, including the divide path that reuses the multiplier, within reach over all sixteen operand pairs of every opcode, all sixteen opcode values included. Back-to-back strobes and idle gaps are also applied, to expose any valid or hold error in the single output register stage.

// File: rtl/tf2_pkg.sv
package tf2_pkg;
  localparam int VAL_W = 2;
  localparam int OP_W  = 4;
  localparam int PAIRS = 2 ** (2 * VAL_W);

  typedef logic [VAL_W-1:0] tf2_t;

  localparam tf2_t TF_ZERO = 2'b00;
  localparam tf2_t TF_POS  = 2'b01;
  localparam tf2_t TF_NAN  = 2'b10;
  localparam tf2_t TF_NEG  = 2'b11;

  typedef enum logic [OP_W-1:0] {
    OP_ADD = 4'd0, OP_SUB = 4'd1, OP_NEG = 4'd2, OP_MUL = 4'd3,
    OP_RCP = 4'd4, OP_DIV = 4'd5, OP_ID  = 4'd6, OP_EQ  = 4'd7,
    OP_LT  = 4'd8, OP_GT  = 4'd9, OP_LE  = 4'd10, OP_GE = 4'd11
  } op_e;

  function automatic logic is_nan(tf2_t x);
    return x == TF_NAN;
  endfunction

  function automatic logic is_cmp(logic [OP_W-1:0] op);
    return (op >= OP_ID) && (op <= OP_GE);
  endfunction

  function automatic int tf_val(tf2_t x);
    case (x)
      TF_POS:  return 1;
      TF_NEG:  return -1;
      default: return 0;
    endcase
  endfunction

  function automatic tf2_t tf_enc(int v);
    case (v)
      0:       return TF_ZERO;
      1:       return TF_POS;
      -1:      return TF_NEG;
      default: return TF_NAN;
    endcase
  endfunction
endpackage

// File: rtl/tf2_mul.sv
module tf2_mul
  import tf2_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
) (
  input  tf2_t a,
  input  tf2_t b,
  output tf2_t y
);
  generate
    if (USE_TABLE) begin : g_table
      tf2_t tbl [PAIRS];
      for (genvar gi = 0; gi < PAIRS; gi++) begin : g_ent
        localparam tf2_t EA = tf2_t'(gi / (2 ** VAL_W));
        localparam tf2_t EB = tf2_t'(gi % (2 ** VAL_W));
        assign tbl[gi] = (is_nan(EA) || is_nan(EB)) ? TF_NAN
                                                     : tf_enc(tf_val(EA) * tf_val(EB));
      end
      assign y = tbl[{a, b}];
    end else begin : g_logic
      always_comb begin
        if (is_nan(a) || is_nan(b))            y = TF_NAN;
        else if (a == TF_ZERO || b == TF_ZERO) y = TF_ZERO;
        else                                   y = (a == b) ? TF_POS : TF_NEG;
      end
    end
  endgenerate

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R5
      mul_nan_chk: assert (!(is_nan(a) || is_nan(b)) || y == TF_NAN);
      // R5
      mul_comm_free_sign_chk: assert (is_nan(y) || a == TF_ZERO || b == TF_ZERO || y != TF_ZERO);
    end
  end
endmodule

// File: rtl/tf2_arith.sv
module tf2_arith
  import tf2_pkg::*;
#(
  parameter bit MUL_TABLE = 1'b0
) (
  input  logic [OP_W-1:0] op,
  input  tf2_t            a,
  input  tf2_t            b,
  output tf2_t            res
);
  tf2_t neg_a, neg_b, addend, sum, rcp_a, rcp_b, prod, quot;

  assign neg_a  = tf2_t'(~a + 1'b1);
  assign neg_b  = tf2_t'(~b + 1'b1);
  assign addend = (op == OP_SUB) ? neg_b : b;
  assign sum    = (is_nan(a) || is_nan(addend)) ? TF_NAN : tf2_t'(a + addend);
  assign rcp_a  = (a == TF_ZERO) ? TF_NAN : a;
  assign rcp_b  = (b == TF_ZERO) ? TF_NAN : b;

  tf2_mul #(.USE_TABLE(MUL_TABLE)) u_mul (.a(a), .b(b),     .y(prod));
  tf2_mul #(.USE_TABLE(MUL_TABLE)) u_div (.a(a), .b(rcp_b), .y(quot));

  always_comb begin
    case (op)
      OP_ADD, OP_SUB: res = sum;
      OP_NEG:         res = neg_a;
      OP_MUL:         res = prod;
      OP_RCP:         res = rcp_a;
      OP_DIV:         res = quot;
      default:        res = TF_NAN;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, a, b})) begin
      // R3
      add_nan_chk: assert (!(op == OP_ADD && (is_nan(a) || is_nan(b))) || res == TF_NAN);
      // R4
      neg_twice_chk: assert (tf2_t'(~neg_a + 1'b1) == a);
    end
  end
endmodule

// File: rtl/tf2_cmp.sv
module tf2_cmp
  import tf2_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  tf2_t            a,
  input  tf2_t            b,
  output logic            flag
);
  logic ident, ord_eq, lt, gt;

  assign ident  = (a == b);
  assign ord_eq = ident && !is_nan(a);
  assign lt = (a[1] & a[0] & ~b[1]) | (~a[1] & ~a[0] & ~b[1] & b[0]);
  assign gt = (b[1] & b[0] & ~a[1]) | (~b[1] & ~b[0] & ~a[1] & a[0]);

  always_comb begin
    case (op)
      OP_ID:   flag = ident;
      OP_EQ:   flag = ord_eq;
      OP_LT:   flag = lt;
      OP_GT:   flag = gt;
      OP_LE:   flag = lt | ord_eq;
      OP_GE:   flag = gt | ord_eq;
      default: flag = 1'b0;
    endcase
  end

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R9
      lt_gt_excl_chk: assert (!(lt && gt));
      // R9
      order_nan_chk: assert (!(is_nan(a) || is_nan(b)) || !(lt || gt));
    end
  end
endmodule

// File: rtl/tf2_alu.sv
module tf2_alu
  import tf2_pkg::*;
#(
  parameter bit MUL_TABLE = 1'b0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [OP_W-1:0] op_i,
  input  tf2_t            a_i,
  input  tf2_t            b_i,
  output logic            out_valid,
  output tf2_t            res_o,
  output logic            flag_o
);
  tf2_t arith_res, res_c;
  logic cmp_flag;

  tf2_arith #(.MUL_TABLE(MUL_TABLE)) u_arith (.op(op_i), .a(a_i), .b(b_i), .res(arith_res));
  tf2_cmp u_cmp (.op(op_i), .a(a_i), .b(b_i), .flag(cmp_flag));

  assign res_c = is_cmp(op_i) ? TF_ZERO : arith_res;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_o     <= TF_ZERO;
      flag_o    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        res_o  <= res_c;
        flag_o <= cmp_flag;
      end
    end
  end

  // R2
  ovalid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(res_o) && $stable(flag_o)));
  // R11
  flag_scope_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !is_cmp(op_i)) |=> !flag_o);
  // R12
  unused_nan_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op_i > OP_GE) |=> (res_o == TF_NAN));
endmodule

// File: tb/tf2_alu_test.sv
module tf2_alu_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [3:0] op_i = 4'd0;
  logic [1:0] a_i = 2'b00, b_i = 2'b00;
  logic       ov0, ov1, fl0, fl1;
  logic [1:0] rs0, rs1;
  int compared = 0, mismatched = 0;

  always #2 clk = ~clk;

  tf2_alu #(.MUL_TABLE(1'b0)) uut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .out_valid(ov0), .res_o(rs0), .flag_o(fl0));
  tf2_alu #(.MUL_TABLE(1'b1)) uut_tbl (.clk(clk), .rst(rst), .in_valid(in_valid), .op_i(op_i),
    .a_i(a_i), .b_i(b_i), .out_valid(ov1), .res_o(rs1), .flag_o(fl1));

  function automatic int val(logic [1:0] x);
    return (x == 2'b01) ? 1 : (x == 2'b11) ? -1 : 0;
  endfunction
  function automatic logic [1:0] enc(int v);
    return (v == 0) ? 2'b00 : (v == 1) ? 2'b01 : (v == -1) ? 2'b11 : 2'b10;
  endfunction

  function automatic logic [1:0] exp_res(logic [3:0] op, logic [1:0] a, logic [1:0] b);
    logic na = (a == 2'b10), nb = (b == 2'b10);
    case (op)
      4'd0: return (na || nb) ? 2'b10 : enc(val(a) + val(b));
      4'd1: return (na || nb) ? 2'b10 : enc(val(a) - val(b));
      4'd2: return na ? 2'b10 : enc(-val(a));
      4'd3: return (na || nb) ? 2'b10 : enc(val(a) * val(b));
      4'd4: return (na || val(a) == 0) ? 2'b10 : a;
      4'd5: return (na || nb || val(b) == 0) ? 2'b10 : enc(val(a) * val(b));
      4'd6, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11: return 2'b00;
      default: return 2'b10;
    endcase
  endfunction

  function automatic logic exp_flag(logic [3:0] op, logic [1:0] a, logic [1:0] b);
    logic ok = (a != 2'b10) && (b != 2'b10);
    case (op)
      4'd6:  return a == b;
      4'd7:  return ok && val(a) == val(b);
      4'd8:  return ok && val(a) < val(b);
      4'd9:  return ok && val(a) > val(b);
      4'd10: return ok && val(a) <= val(b);
      4'd11: return ok && val(a) >= val(b);
      default: return 1'b0;
    endcase
  endfunction

  function automatic string tag(logic [3:0] op);
    case (op)
      4'd0: return "R3";  4'd1, 4'd2: return "R4";  4'd3: return "R5";
      4'd4, 4'd5: return "R6";  4'd6: return "R7";  4'd7: return "R8";
      4'd8, 4'd9: return "R9";  4'd10, 4'd11: return "R10";
      default: return "R12";
    endcase
  endfunction

  task automatic check(string req, string what, logic [1:0] got, logic [1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s %s: got %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic check_out(logic [3:0] op, logic [1:0] a, logic [1:0] b);
    string w = $sformatf("op=%0d a=%b b=%b", op, a, b);
    check(tag(op), {w, " res"}, rs0, exp_res(op, a, b));
    check(is_cmp_op(op) ? tag(op) : "R11", {w, " flag"}, {1'b0, fl0}, {1'b0, exp_flag(op, a, b)});
    check("R2", {w, " out_valid"}, {1'b0, ov0}, 2'b01);
    check("R13", {w, " table res"}, rs1, rs0);
    check("R13", {w, " table flag"}, {1'b0, fl1}, {1'b0, fl0});
  endtask

  function automatic logic is_cmp_op(logic [3:0] op);
    return op >= 4'd6 && op <= 4'd11;
  endfunction

  task automatic drive(logic [3:0] op, logic [1:0] a, logic [1:0] b);
    op_i = op; a_i = a; b_i = b; in_valid = 1'b1;
  endtask

  task automatic test_reset();
    @(negedge clk); @(negedge clk);
    check("R1", "reset out_valid", {1'b0, ov0}, 2'b00);
    check("R1", "reset res", rs0, 2'b00);
    check("R1", "reset flag", {1'b0, fl0}, 2'b00);
    rst = 1'b0;
  endtask

  task automatic test_all_ops();
    for (int op = 0; op < 16; op++)
      for (int p = 0; p < 16; p++) begin
        @(negedge clk);
        drive(4'(op), 2'(p / 4), 2'(p % 4));
        @(negedge clk);
        in_valid = 1'b0;
        check_out(4'(op), 2'(p / 4), 2'(p % 4));
      end
  endtask

  task automatic test_back_to_back();
    @(negedge clk); drive(4'd0, 2'b01, 2'b01);
    @(negedge clk); check_out(4'd0, 2'b01, 2'b01); drive(4'd8, 2'b11, 2'b01);
    @(negedge clk); check_out(4'd8, 2'b11, 2'b01); drive(4'd6, 2'b10, 2'b10);
    @(negedge clk); check_out(4'd6, 2'b10, 2'b10); in_valid = 1'b0;
  endtask

  task automatic test_hold();
    @(negedge clk); drive(4'd9, 2'b01, 2'b00);
    @(negedge clk); in_valid = 1'b0; op_i = 4'd0; a_i = 2'b10; b_i = 2'b10;
    check_out(4'd9, 2'b01, 2'b00);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R2", "idle out_valid", {1'b0, ov0}, 2'b00);
      check("R2", "idle res held", rs0, 2'b00);
      check("R2", "idle flag held", {1'b0, fl0}, 2'b01);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  initial begin
    test_reset();
    test_all_ops();
    test_back_to_back();
    test_hold();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    compared++; mismatched++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end
endmodule